// File: doc/BRIEF.md
# USB Receive Deserializer with Line-State Register

This block sits behind the analog receiver and the clock/data recovery of a USB 2.0 physical layer. It takes one recovered line level per strobe, together with the raw D+ and D- levels. From these it produces parallel receive data and status on the parallel clock. It first waits for the packet-start pattern. It then decodes NRZI, strips the stuffed zeros and packs the resulting data bits into bytes or 16-bit words. It stops the packet on single-ended zero or on a stuffing violation.

Serial bits arrive as single-cycle strobes on the parallel clock, and a removed stuffed bit or an idle cycle leaves a gap in that stream. A staging register keeps the partial word across such gaps, so a gap never shifts or splits a word. A separate path registers the two raw line levels as a two-bit line state. A mode input can switch the receiver to raw reception, in which the line level is the data bit.

Top module: `usb_rx_deser`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `rx_active`, `rx_valid`, `rx_error` and `line_state` are all 0.
- R2: Line level J is `bit_lvl`=1 and K is `bit_lvl`=0. `rx_active` rises at the clock edge that samples a strobed K following a strobed K, when at least SYNC_MIN level changes came directly before that pair. A shorter run of changes does not start a packet.
- R3: In normal mode (`op_mode` other than 2'b10), a data bit is 1 when the strobed level equals the previous strobed level and 0 when it differs. Data bits fill `rx_data` from bit 0 upward.
- R4: In normal mode the run of decoded 1s counts the final 1 of the start pattern. After a run of six, a following 0 is discarded. A following 1 instead makes `rx_error` high for exactly one clock and drops `rx_active` at that same edge.
- R5: `rx_valid` is a one-clock pulse, raised once for every WORD_W accepted data bits and at the same edge at which `rx_data` takes the new word. It only follows a cycle in which `rx_active` was high.
- R6: A strobe with `dp`=0 and `dm`=0 while active drops `rx_active` at that edge. A partly filled word is discarded and gives no `rx_valid`.
- R7: With `op_mode`=2'b10 each strobed level after the start pattern is the data bit itself (J=1, K=0). No bit is removed and no stuffing error is raised.
- R8: `line_state` bit 0 follows `dp` and bit 1 follows `dm`, delayed by exactly LS_STAGES clocks, whether or not a strobe is present.
- R9: Cycles with `bit_en` low change neither the decoded data nor the fill of the staging register.
- R10: With WORD_W=16 the first data byte of a pair lands in `rx_data[7:0]` and the second in `rx_data[15:8]`, with one `rx_valid` per pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous reset, active high |
| op_mode | input | 2 | Operating mode; 2'b10 selects raw reception |
| bit_en | input | 1 | Strobe: a recovered bit is present this cycle |
| bit_lvl | input | 1 | Recovered line level, 1 = J, 0 = K |
| dp | input | 1 | Raw D+ level |
| dm | input | 1 | Raw D- level |
| rx_data | output | WORD_W | Received word |
| rx_valid | output | 1 | One-clock pulse when `rx_data` holds a new word |
| rx_active | output | 1 | High from the start pattern to the end of the packet |
| rx_error | output | 1 | One-clock pulse on a stuffing violation |
| line_state | output | 2 | Registered {D-, D+} |

## Verification
A wrong NRZI reference level or ones count shows up at the ports within one byte. The word takes the wrong value, or a stuffed zero is kept as data, which moves every later bit by one place. This also makes `rx_valid` appear one strobe early or late. A staging counter that is not cleared at packet end leaves the next packet's first word misaligned, so that word is wrong on its first `rx_valid`. A miscounted start-pattern detector shows up on the very first data bit: `rx_active` rises one strobe early or late, or not at all.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

   localparam int unsigned STUFF_RUN = 6;

   localparam logic LVL_J = 1'b1;
   localparam logic LVL_K = 1'b0;

   typedef enum logic [1:0] {
      OPM_NORMAL  = 2'b00,
      OPM_NODRIVE = 2'b01,
      OPM_RAW     = 2'b10,
      OPM_RSVD    = 2'b11
   } opmode_e;

   // unchanged level decodes to 1, a transition to 0
   function automatic logic nrzi_bit(input logic cur, input logic prev);
      return ~(cur ^ prev);
   endfunction

endpackage

// File: rtl/urx_line_sync.sv
module urx_line_sync #(
   parameter int unsigned LS_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] ls_in,
   output logic [1:0] ls_out
);

   initial begin
      assert (LS_STAGES >= 1 && LS_STAGES <= 4)
         else $error("urx_line_sync: LS_STAGES out of range");
   end

   generate
      if (LS_STAGES == 1) begin : g_single
         logic [1:0] ls_q;
         always_ff @(posedge clk) begin
            if (rst) ls_q <= '0;
            else     ls_q <= ls_in;
         end
         assign ls_out = ls_q;
      end else begin : g_chain
         localparam int unsigned PW = 2 * LS_STAGES;
         logic [PW-1:0] pipe_q;
         always_ff @(posedge clk) begin
            if (rst) pipe_q <= '0;
            else     pipe_q <= {pipe_q[PW-3:0], ls_in};
         end
         assign ls_out = pipe_q[PW-1:PW-2];
      end
   endgenerate

endmodule

// File: rtl/urx_sync_detect.sv
module urx_sync_detect
   import usb_rx_pkg::*;
#(
   parameter int unsigned SYNC_MIN = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic bit_lvl,
   input  logic se0,
   input  logic armed,
   output logic sync_hit
);

   localparam int unsigned CW = $clog2(SYNC_MIN + 1);

   logic          prev_lvl;
   logic [CW-1:0] alt_cnt;
   logic          run_full;

   initial begin
      assert (SYNC_MIN >= 1)
         else $error("urx_sync_detect: SYNC_MIN must be at least 1");
   end

   assign run_full = (alt_cnt == CW'(SYNC_MIN));

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_lvl <= LVL_J;
         alt_cnt  <= '0;
      end else if (bit_en) begin
         if (se0) begin
            prev_lvl <= LVL_J;
            alt_cnt  <= '0;
         end else begin
            prev_lvl <= bit_lvl;
            if (bit_lvl != prev_lvl) begin
               if (!run_full) alt_cnt <= alt_cnt + 1'b1;
            end else begin
               alt_cnt <= '0;
            end
         end
      end
   end

   assign sync_hit = armed && bit_en && !se0 && run_full &&
                     (bit_lvl == LVL_K) && (prev_lvl == LVL_K);

   AST_SYNC_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      alt_cnt <= CW'(SYNC_MIN)); // R2

endmodule

// File: rtl/urx_unstuff.sv
module urx_unstuff
   import usb_rx_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic bit_lvl,
   input  logic se0,
   input  logic raw_mode,
   input  logic active,
   input  logic start,
   output logic data_bit,
   output logic data_take,
   output logic stuff_err
);

   localparam int unsigned OW = $clog2(STUFF_RUN + 1);

   logic          prev_lvl;
   logic [OW-1:0] ones_cnt;
   logic          dec_bit;
   logic          live;
   logic          at_limit;

   assign dec_bit  = raw_mode ? bit_lvl : nrzi_bit(bit_lvl, prev_lvl);
   assign live     = bit_en && active && !se0;
   assign at_limit = (ones_cnt == OW'(STUFF_RUN));
   assign data_bit = dec_bit;

   always_comb begin
      data_take = 1'b0;
      stuff_err = 1'b0;
      if (live) begin
         if (raw_mode)      data_take = 1'b1;
         else if (at_limit) stuff_err = dec_bit;
         else               data_take = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_lvl <= LVL_J;
      end else if (bit_en) begin
         prev_lvl <= se0 ? LVL_J : bit_lvl;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ones_cnt <= '0;
      end else if (start) begin
         ones_cnt <= OW'(1);
      end else if (live && !raw_mode) begin
         if (at_limit)     ones_cnt <= '0;
         else if (dec_bit) ones_cnt <= ones_cnt + 1'b1;
         else              ones_cnt <= '0;
      end else if (!active) begin
         ones_cnt <= '0;
      end
   end

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
      ones_cnt <= OW'(STUFF_RUN)); // R4

endmodule

// File: rtl/urx_word_stage.sv
module urx_word_stage #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              take,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word,
   output logic              word_ok
);

   localparam int unsigned CW = $clog2(WORD_W);

   logic [WORD_W-1:0] stage_q;
   logic [WORD_W-1:0] stage_nx;
   logic [CW-1:0]     fill_q;
   logic              last_bit;

   initial begin
      assert (WORD_W == 8 || WORD_W == 16)
         else $error("urx_word_stage: WORD_W must be 8 or 16");
   end

   assign last_bit = (fill_q == CW'(WORD_W - 1));

   always_comb begin
      stage_nx         = stage_q;
      stage_nx[fill_q] = bit_in;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= '0;
         fill_q  <= '0;
         word    <= '0;
         word_ok <= 1'b0;
      end else begin
         word_ok <= 1'b0;
         if (clear) begin
            fill_q <= '0;
         end else if (take) begin
            stage_q <= stage_nx;
            if (last_bit) begin
               word    <= stage_nx;
               word_ok <= 1'b1;
               fill_q  <= '0;
            end else begin
               fill_q <= fill_q + 1'b1;
            end
         end
      end
   end

   AST_WORD_PULSE: assert property (@(posedge clk) disable iff (rst)
      word_ok |=> !word_ok); // R5

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      clear |=> (fill_q == '0)); // R6

endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser
   import usb_rx_pkg::*;
#(
   parameter int unsigned WORD_W    = 8,
   parameter int unsigned SYNC_MIN  = 5,
   parameter int unsigned LS_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        op_mode,
   input  logic              bit_en,
   input  logic              bit_lvl,
   input  logic              dp,
   input  logic              dm,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_active,
   output logic              rx_error,
   output logic [1:0]        line_state
);

   logic se0;
   logic raw_mode;
   logic sync_hit;
   logic data_bit;
   logic data_take;
   logic stuff_err;
   logic eop_hit;

   assign se0      = !dp && !dm;
   assign raw_mode = (opmode_e'(op_mode) == OPM_RAW);
   assign eop_hit  = rx_active && bit_en && se0;

   urx_sync_detect #(.SYNC_MIN(SYNC_MIN)) i_sync (
      .clk      (clk),
      .rst      (rst),
      .bit_en   (bit_en),
      .bit_lvl  (bit_lvl),
      .se0      (se0),
      .armed    (!rx_active),
      .sync_hit (sync_hit)
   );

   urx_unstuff i_unstuff (
      .clk       (clk),
      .rst       (rst),
      .bit_en    (bit_en),
      .bit_lvl   (bit_lvl),
      .se0       (se0),
      .raw_mode  (raw_mode),
      .active    (rx_active),
      .start     (sync_hit),
      .data_bit  (data_bit),
      .data_take (data_take),
      .stuff_err (stuff_err)
   );

   urx_word_stage #(.WORD_W(WORD_W)) i_stage (
      .clk     (clk),
      .rst     (rst),
      .clear   (!rx_active),
      .take    (data_take),
      .bit_in  (data_bit),
      .word    (rx_data),
      .word_ok (rx_valid)
   );

   urx_line_sync #(.LS_STAGES(LS_STAGES)) i_lsync (
      .clk    (clk),
      .rst    (rst),
      .ls_in  ({dm, dp}),
      .ls_out (line_state)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_active <= 1'b0;
         rx_error  <= 1'b0;
      end else begin
         rx_error <= stuff_err;
         if (sync_hit)                  rx_active <= 1'b1;
         else if (stuff_err || eop_hit) rx_active <= 1'b0;
      end
   end

   AST_VALID_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> $past(rx_active)); // R5

   AST_ERR_ENDS_PACKET: assert property (@(posedge clk) disable iff (rst)
      rx_error |-> !rx_active); // R4

   AST_ERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
      rx_error |=> !rx_error); // R4

   AST_SE0_ENDS_PACKET: assert property (@(posedge clk) disable iff (rst)
      (rx_active && bit_en && !dp && !dm) |=> !rx_active); // R6

   AST_RAW_NO_ERROR: assert property (@(posedge clk) disable iff (rst)
      rx_error |-> ($past(op_mode) != 2'b10)); // R7

endmodule

// File: tb/test_usb_rx_deser.sv
module test_usb_rx_deser;

   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  op_mode;
   logic        bit_en;
   logic        bit_lvl;
   logic        dp;
   logic        dm;

   logic [7:0]  d8;
   logic        v8, a8, e8;
   logic [1:0]  ls8;
   logic [15:0] d16;
   logic        v16, a16, e16;
   logic [1:0]  ls16;

   int          vectors = 0;
   int          fails   = 0;

   logic [7:0]  cap8  [16];
   logic [15:0] cap16 [16];
   int          n8  = 0;
   int          n16 = 0;
   int          nerr = 0;

   logic        cur;
   int          ones;
   logic        raw_tx;

   always #4 clk = ~clk;

   usb_rx_deser i_usb_rx_deser (
      .clk(clk), .rst(rst), .op_mode(op_mode), .bit_en(bit_en),
      .bit_lvl(bit_lvl), .dp(dp), .dm(dm), .rx_data(d8), .rx_valid(v8),
      .rx_active(a8), .rx_error(e8), .line_state(ls8)
   );

   usb_rx_deser #(.WORD_W(16)) i_usb_rx_deser_w16 (
      .clk(clk), .rst(rst), .op_mode(op_mode), .bit_en(bit_en),
      .bit_lvl(bit_lvl), .dp(dp), .dm(dm), .rx_data(d16), .rx_valid(v16),
      .rx_active(a16), .rx_error(e16), .line_state(ls16)
   );

   always @(negedge clk) begin
      if (v8 && n8 < 16) begin cap8[n8] = d8; n8++; end
      if (v16 && n16 < 16) begin cap16[n16] = d16; n16++; end
      if (e8) nerr++;
   end

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic en, input logic lvl, input logic se0);
      bit_en  = en;
      bit_lvl = lvl;
      dp      = se0 ? 1'b0 : lvl;
      dm      = se0 ? 1'b0 : ~lvl;
      @(negedge clk);
   endtask

   task automatic send_lvl(input logic lvl);
      drive(1'b1, lvl, 1'b0);
      cur = lvl;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 1'b0);
      cur = 1'b1;
   endtask

   task automatic clear_cap();
      n8 = 0; n16 = 0; nerr = 0;
   endtask

   // seven alternating levels starting with K from idle J
   task automatic sync_body();
      for (int i = 0; i < 7; i++) send_lvl(i[0] ? 1'b1 : 1'b0);
   endtask

   task automatic sync_end();
      send_lvl(1'b0);
      ones = 1;
   endtask

   task automatic send_bit(input logic b, input logic gap);
      if (raw_tx) begin
         send_lvl(b);
      end else begin
         send_lvl(b ? cur : ~cur);
         ones = b ? ones + 1 : 0;
         if (ones == 6) begin
            if (gap) drive(1'b0, cur, 1'b0);
            send_lvl(~cur);
            ones = 0;
         end
      end
      if (gap) drive(1'b0, cur, 1'b0);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic gap);
      for (int i = 0; i < 8; i++) send_bit(b[i], gap);
   endtask

   task automatic send_eop();
      drive(1'b1, 1'b0, 1'b1);
      drive(1'b1, 1'b0, 1'b1);
      drive(1'b1, 1'b1, 1'b0);
      idle(3);
   endtask

   task automatic t_reset();
      chk("R1 active in reset", a8, 0);
      chk("R1 valid in reset", v8, 0);
      chk("R1 error in reset", e8, 0);
      chk("R1 line_state in reset", ls8, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 active after reset", a8, 0);
      chk("R1 line_state first sample", ls8, 0);
      idle(4);
   endtask

   task automatic t_basic();
      clear_cap();
      sync_body();
      chk("R2 no start before KK", a8, 0);
      sync_end();
      chk("R2 active on KK", a8, 1);
      send_byte(8'hA5, 1'b0);
      send_byte(8'h3C, 1'b0);
      chk("R2 active during packet", a8, 1);
      send_eop();
      chk("R3 word count", n8, 2);
      chk("R3 first byte", cap8[0], 8'hA5);
      chk("R5 second byte", cap8[1], 8'h3C);
      chk("R10 wide word count", n16, 1);
      chk("R10 wide word", cap16[0], 16'h3CA5);
      chk("R6 inactive after end", a8, 0);
   endtask

   task automatic t_short_sync();
      clear_cap();
      send_lvl(1'b0); send_lvl(1'b1); send_lvl(1'b0); send_lvl(1'b0);
      chk("R2 short run no start", a8, 0);
      for (int i = 0; i < 10; i++) send_lvl(1'b1);
      chk("R2 still idle", a8, 0);
      idle(2);
      chk("R2 no words", n8, 0);
   endtask

   task automatic t_stuff();
      clear_cap();
      sync_body(); sync_end();
      send_byte(8'hFF, 1'b0);
      send_byte(8'h7E, 1'b0);
      send_byte(8'hFC, 1'b0);
      send_eop();
      chk("R4 stuffed count", n8, 3);
      chk("R4 stuffed byte 0", cap8[0], 8'hFF);
      chk("R4 stuffed byte 1", cap8[1], 8'h7E);
      chk("R4 stuffed byte 2", cap8[2], 8'hFC);
      chk("R4 no error", nerr, 0);
   endtask

   task automatic t_stuff_err();
      clear_cap();
      sync_body(); sync_end();
      for (int i = 0; i < 5; i++) send_lvl(cur);
      chk("R4 six ones still active", a8, 1);
      chk("R4 six ones no error", e8, 0);
      send_lvl(cur);
      chk("R4 error raised", e8, 1);
      chk("R4 active dropped", a8, 0);
      chk("R4 wide error raised", e16, 1);
      send_lvl(cur);
      chk("R4 error one clock", e8, 0);
      send_eop();
      chk("R4 no words on error", n8, 0);
   endtask

   task automatic t_eop_partial();
      clear_cap();
      sync_body(); sync_end();
      send_byte(8'h12, 1'b0);
      send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
      drive(1'b1, 1'b0, 1'b1);
      chk("R6 active drops on SE0", a8, 0);
      drive(1'b1, 1'b0, 1'b1);
      drive(1'b1, 1'b1, 1'b0);
      idle(3);
      chk("R6 partial discarded", n8, 1);
      chk("R6 full byte kept", cap8[0], 8'h12);
      clear_cap();
      sync_body(); sync_end();
      send_byte(8'h81, 1'b0);
      send_eop();
      chk("R6 next packet aligned", cap8[0], 8'h81);
   endtask

   task automatic t_gaps();
      clear_cap();
      sync_body(); sync_end();
      send_byte(8'h96, 1'b1);
      send_byte(8'hFF, 1'b1);
      send_eop();
      chk("R9 gapped count", n8, 2);
      chk("R9 gapped byte 0", cap8[0], 8'h96);
      chk("R9 gapped byte 1", cap8[1], 8'hFF);
   endtask

   task automatic t_raw();
      clear_cap();
      op_mode = 2'b10;
      raw_tx  = 1'b1;
      idle(1);
      sync_body(); sync_end();
      send_byte(8'hFF, 1'b0);
      send_byte(8'hFF, 1'b0);
      send_byte(8'h5A, 1'b0);
      chk("R7 no error in raw", e8, 0);
      send_eop();
      chk("R7 raw count", n8, 3);
      chk("R7 raw byte 0", cap8[0], 8'hFF);
      chk("R7 raw byte 2", cap8[2], 8'h5A);
      chk("R7 raw no error seen", nerr, 0);
      op_mode = 2'b00;
      raw_tx  = 1'b0;
      idle(1);
   endtask

   task automatic t_linestate();
      bit_en = 1'b0; dp = 1'b0; dm = 1'b1;
      @(negedge clk);
      chk("R8 one clock old value", ls8, 2'b01);
      @(negedge clk);
      chk("R8 D- on bit 1", ls8, 2'b10);
      dp = 1'b0; dm = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R8 SE0", ls8, 2'b00);
      dp = 1'b1; dm = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R8 both high", ls16, 2'b11);
      idle(3);
      chk("R8 back to J", ls8, 2'b01);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; op_mode = 2'b00; raw_tx = 1'b0; ones = 0; cur = 1'b1;
      bit_en = 1'b0; bit_lvl = 1'b1; dp = 1'b1; dm = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      t_basic();
      t_short_sync();
      t_stuff();
      t_stuff_err();
      t_eop_partial();
      t_gaps();
      t_raw();
      t_linestate();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule